// File: doc/BRIEF.md
# Eight-Port Self-Steering Shuffle-Exchange Router

This block moves packets from eight input ports to eight output ports through three columns of two-by-two switches. Each column is preceded by a perfect-shuffle link pattern, which rotates the three-bit port index left by one place. Each switch steers a packet by one bit of its destination, taking the most significant bit in the first column. A bit of 0 picks the switch's upper (even) output and a bit of 1 picks its lower (odd) output. After the three columns, the packet sits on the output port equal to its destination.

Two packets that need the same switch output in the same cycle cannot both pass, so some destination patterns complete only partly in one cycle. The block settles this at injection. A combinational pass works out the whole route for every valid input in that cycle. At each contested switch the packet on the upper input wins. Every input whose packet did not survive to the last column gets a stall. That input holds its packet and offers it again on the next cycle. Admitted packets then move through three registered stages. They never meet a packet from a different injection cycle, so delivery takes a fixed time.

Each output port carries a valid flag, the payload and the index of the input the packet came from.

Top module: `omega_router`

## Requirements
- R1: While reset is applied and after it is released with no traffic, every output valid bit and every stall bit is 0.
- R2: An admitted packet appears on the output port whose index equals its 3-bit destination. That port shows the packet's payload, and its source field holds the input index.
- R3: An admitted packet is presented at its output on the third rising clock edge, counting the edge that captures it at the input. Its output valid bit is 0 after the first and second edges.
- R4: A stall is raised only for an input whose valid bit is 1. A stalled packet is not delivered from that cycle's offer.
- R5: In the first column, inputs j and j+4 share a switch, and input j is the upper one. If both want the same output, input j+4 is stalled. For example, input 0 to destination 0 together with input 4 to destination 1 stalls input 4.
- R6: Contention in a later column also resolves in favour of the upper input. Input 1 to destination 0 together with input 3 to destination 1 meet in the second column, and input 3 is stalled.
- R7: A stalled input that keeps its packet offered is admitted on a later cycle when it meets no conflict. It is then delivered one cycle after the packet that beat it.
- R8: Whenever at least one input is valid, at least one valid input is admitted in that cycle.
- R9: Patterns that meet no conflict are delivered in full in a single cycle. This includes the identity pattern and a cyclic shift of all eight destinations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 8 | Packet offered on each input port |
| in_dest | input | 24 | 3-bit destination per input, port p at bits [3p+2:3p] |
| in_data | input | 128 | Payload per input, port p at bits [16p+15:16p] |
| in_stall | output | 8 | Input must hold its packet and retry next cycle |
| out_valid | output | 8 | Packet present on each output port |
| out_src | output | 24 | Source input index per output port |
| out_data | output | 128 | Payload per output port |

## Verification
The assertions check several properties on every cycle. Stalls go only to valid inputs, and some valid input always makes progress. No two packets ever contend inside the registered stages. Every packet sits on the port matching its destination. Every delivery traces back to an admission from that source three cycles earlier. Only the bench scenarios can show which input wins a given conflict, in the first column or in a later one. The same holds for whether a held packet is delivered on retry, and whether whole conflict-free patterns arrive together with the correct payloads.

// File: rtl/omega_router.sv
`timescale 1ns/1ps
module omega_router #(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   in_valid,
  input  logic [N*$clog2(N)-1:0] in_dest,
  input  logic [N*W-1:0] in_data,
  output logic [N-1:0]   in_stall,
  output logic [N-1:0]   out_valid,
  output logic [N*$clog2(N)-1:0] out_src,
  output logic [N*W-1:0] out_data
);
  localparam int LG = $clog2(N);
  localparam int S  = LG;
  localparam int H  = N / 2;

  function automatic int shuf(input int p);
    return ((p << 1) | (p >> (LG - 1))) & (N - 1);
  endfunction

  // admission pass: full route of this cycle's offers
  logic [N-1:0]  wv  [S+1];
  logic [LG-1:0] ws  [S+1][N];
  logic [N-1:0]  shv [S];
  logic [LG-1:0] shs [S][N];
  logic [N-1:0]  grant;

  always_comb begin
    wv[0] = in_valid;
    for (int p = 0; p < N; p++) ws[0][p] = LG'(p);
    for (int s = 0; s < S; s++) begin
      for (int p = 0; p < N; p++) begin
        shv[s][shuf(p)] = wv[s][p];
        shs[s][shuf(p)] = ws[s][p];
      end
      wv[s+1] = '0;
      for (int p = 0; p < N; p++) ws[s+1][p] = '0;
      for (int j = 0; j < H; j++) begin
        logic ba, bb;
        ba = in_dest[int'(shs[s][2*j])   * LG + (S - 1 - s)];
        bb = in_dest[int'(shs[s][2*j+1]) * LG + (S - 1 - s)];
        if (shv[s][2*j]) begin
          wv[s+1][2*j + int'(ba)] = 1'b1;
          ws[s+1][2*j + int'(ba)] = shs[s][2*j];
        end
        if (shv[s][2*j+1] && !(shv[s][2*j] && ba == bb)) begin
          wv[s+1][2*j + int'(bb)] = 1'b1;
          ws[s+1][2*j + int'(bb)] = shs[s][2*j+1];
        end
      end
    end
  end

  always_comb begin
    grant = '0;
    for (int p = 0; p < N; p++)
      if (wv[S][p]) grant[ws[S][p]] = 1'b1;
  end

  assign in_stall = in_valid & ~grant;

  // registered stages
  logic [N-1:0]  pv   [S];
  logic [LG-1:0] pd   [S][N];
  logic [LG-1:0] psrc [S][N];
  logic [W-1:0]  pdat [S][N];

  logic [N-1:0]  tv   [S];
  logic [LG-1:0] td   [S][N];
  logic [LG-1:0] tsrc [S][N];
  logic [W-1:0]  tdat [S][N];

  logic [N-1:0]  nv   [S];
  logic [LG-1:0] nd   [S][N];
  logic [LG-1:0] nsrc [S][N];
  logic [W-1:0]  ndat [S][N];

  always_comb begin
    for (int s = 0; s < S; s++) begin
      for (int p = 0; p < N; p++) begin
        if (s == 0) begin
          tv[s][shuf(p)]   = in_valid[p] & grant[p];
          td[s][shuf(p)]   = in_dest[p*LG +: LG];
          tsrc[s][shuf(p)] = LG'(p);
          tdat[s][shuf(p)] = in_data[p*W +: W];
        end else begin
          tv[s][shuf(p)]   = pv[s-1][p];
          td[s][shuf(p)]   = pd[s-1][p];
          tsrc[s][shuf(p)] = psrc[s-1][p];
          tdat[s][shuf(p)] = pdat[s-1][p];
        end
      end
      for (int j = 0; j < H; j++) begin
        for (int k = 0; k < 2; k++) begin
          logic ta, tb;
          ta = tv[s][2*j]   && (td[s][2*j][S-1-s]   == k[0]);
          tb = tv[s][2*j+1] && (td[s][2*j+1][S-1-s] == k[0]);
          nv[s][2*j+k]   = ta | tb;
          nd[s][2*j+k]   = ta ? td[s][2*j]   : td[s][2*j+1];
          nsrc[s][2*j+k] = ta ? tsrc[s][2*j] : tsrc[s][2*j+1];
          ndat[s][2*j+k] = ta ? tdat[s][2*j] : tdat[s][2*j+1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < S; s++) begin
        pv[s] <= '0;
        for (int p = 0; p < N; p++) begin
          pd[s][p]   <= '0;
          psrc[s][p] <= '0;
          pdat[s][p] <= '0;
        end
      end
    end else begin
      for (int s = 0; s < S; s++) begin
        pv[s] <= nv[s];
        for (int p = 0; p < N; p++) begin
          pd[s][p]   <= nd[s][p];
          psrc[s][p] <= nsrc[s][p];
          pdat[s][p] <= ndat[s][p];
        end
      end
    end
  end

  assign out_valid = pv[S-1];
  for (genvar p = 0; p < N; p++) begin : g_out
    assign out_src[p*LG +: LG] = psrc[S-1][p];
    assign out_data[p*W +: W]  = pdat[S-1][p];
  end

  // checks
  for (genvar i = 0; i < N; i++) begin : g_chk_in
    AST_STALL_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      in_stall[i] |-> in_valid[i]); // R4
  end

  AST_SOME_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid != '0) |-> (in_stall != in_valid)); // R8

  for (genvar s = 1; s < S; s++) begin : g_chk_stage
    for (genvar j = 0; j < H; j++) begin : g_sw
      AST_NO_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        (tv[s][2*j] && tv[s][2*j+1]) |->
        (td[s][2*j][S-1-s] != td[s][2*j+1][S-1-s])); // R6
    end
  end

  for (genvar p = 0; p < N; p++) begin : g_chk_out
    AST_PORT_MATCHES_DEST: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[p] |-> (pd[S-1][p] == LG'(p))); // R2
    for (genvar i = 0; i < N; i++) begin : g_src
      AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid[p] && out_src[p*LG +: LG] == LG'(i)) |->
        $past(in_valid[i] && !in_stall[i], 3)); // R3
    end
  end
endmodule

// File: tb/omega_router_tb.sv
`timescale 1ns/1ps
module omega_router_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   in_valid = '0;
  logic [23:0]  in_dest = '0;
  logic [127:0] in_data = '0;
  logic [7:0]   in_stall;
  logic [7:0]   out_valid;
  logic [23:0]  out_src;
  logic [127:0] out_data;

  int total = 0;
  int fails = 0;

  omega_router u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
    .in_data(in_data), .in_stall(in_stall), .out_valid(out_valid),
    .out_src(out_src), .out_data(out_data)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic offer(input int i, input int d, input logic [15:0] v);
    in_valid[i] = 1'b1;
    in_dest[i*3 +: 3] = 3'(d);
    in_data[i*16 +: 16] = v;
  endtask

  task automatic clear_inputs();
    in_valid = '0;
    in_dest = '0;
    in_data = '0;
  endtask

  task automatic check_port(input string req, input int p, input int src, input logic [15:0] v);
    check({req, " valid"}, 32'(out_valid[p]), 32'd1);
    check({req, " src"}, 32'(out_src[p*3 +: 3]), 32'(src));
    check({req, " data"}, 32'(out_data[p*16 +: 16]), 32'(v));
  endtask

  task automatic t_reset();
    check("R1 out_valid in reset", 32'(out_valid), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid idle", 32'(out_valid), 32'h0);
    check("R1 stall idle", 32'(in_stall), 32'h0);
  endtask

  task automatic t_single();
    @(negedge clk);
    offer(3, 6, 16'hBEEF);
    #1 check("R4 no stall single", 32'(in_stall), 32'h0);
    @(negedge clk); clear_inputs();
    check("R3 not after edge 1", 32'(out_valid), 32'h0);
    @(negedge clk);
    check("R3 not after edge 2", 32'(out_valid), 32'h0);
    @(negedge clk);
    check("R3 present after edge 3", 32'(out_valid), 32'h40);
    check_port("R2 3->6", 6, 3, 16'hBEEF);
    @(negedge clk);
    check("R3 one cycle only", 32'(out_valid), 32'h0);
  endtask

  task automatic t_pattern(input string req, input int shift);
    @(negedge clk);
    for (int i = 0; i < 8; i++) offer(i, (i + shift) % 8, 16'h100 + 16'(i));
    #1 check({req, " no stall"}, 32'(in_stall), 32'h0);
    @(negedge clk); clear_inputs();
    @(negedge clk);
    @(negedge clk);
    check({req, " all valid"}, 32'(out_valid), 32'hFF);
    for (int p = 0; p < 8; p++) begin
      int s = (p - shift + 8) % 8;
      check({req, " src"}, 32'(out_src[p*3 +: 3]), 32'(s));
      check({req, " data"}, 32'(out_data[p*16 +: 16]), 32'h100 + 32'(s));
    end
  endtask

  task automatic t_first_column();
    @(negedge clk);
    offer(0, 0, 16'h0A0A);
    offer(4, 1, 16'h4B4B);
    #1 check("R5 input 4 stalled", 32'(in_stall), 32'h10);
    check("R8 progress", 32'(in_stall != in_valid), 32'd1);
    @(negedge clk);
    in_valid[0] = 1'b0;
    #1 check("R7 retry not stalled", 32'(in_stall), 32'h0);
    @(negedge clk); clear_inputs();
    @(negedge clk);
    check("R5 only winner delivered", 32'(out_valid), 32'h01);
    check_port("R5 winner", 0, 0, 16'h0A0A);
    @(negedge clk);
    check("R7 retried delivered", 32'(out_valid), 32'h02);
    check_port("R7 retried", 1, 4, 16'h4B4B);
    @(negedge clk);
    check("R4 no duplicate", 32'(out_valid), 32'h0);
  endtask

  task automatic t_later_column();
    @(negedge clk);
    offer(1, 0, 16'h1111);
    offer(3, 1, 16'h3333);
    offer(6, 7, 16'h6666);
    #1 check("R6 input 3 stalled", 32'(in_stall), 32'h08);
    @(negedge clk); clear_inputs();
    @(negedge clk);
    @(negedge clk);
    check("R6 winners delivered", 32'(out_valid), 32'h81);
    check_port("R6 upper winner", 0, 1, 16'h1111);
    check_port("R2 bystander", 7, 6, 16'h6666);
  endtask

  initial begin
    t_reset();
    t_single();
    t_pattern("R9 identity", 0);
    t_pattern("R9 shift", 1);
    t_first_column();
    t_later_column();
    repeat (4) @(negedge clk);
    check("R1 drains idle", 32'(out_valid), 32'h0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule